// File: doc/BRIEF.md
# Monitor Sync Pulse Reshaper

This block sits between a CRTC-style video timing generator and the sync outputs that drive a 15 kHz, 50 Hz TV-rate monitor. The timing generator's horizontal sync can be wide and sits wherever its programming puts it. A monitor expects a narrower pulse that starts a little later. The block therefore delays the horizontal pulse by a fixed number of characters and clips it to a fixed width. It also moves vertical sync transitions so that they fall on line boundaries. From the two reshaped pulses it forms an active-low composite sync.

All sequencing advances on a one-cycle character enable, nominally 1 MHz, inside a faster system clock. Inputs are sampled only on enabled cycles. A character counter restarts when the sampled horizontal sync first goes high. This counter is exported so that the pulse start and end can be checked against character positions.

The horizontal shaper is a four-state machine with these states:
- HS_IDLE: no CRTC pulse is in progress.
- HS_WAIT: counting out the delay.
- HS_PULSE: the monitor pulse is active.
- HS_HOLD: the CRTC pulse is still high but the monitor pulse has ended.

The transitions are:
- START: any state goes to HS_WAIT on a rising edge, or straight to HS_PULSE when the delay is zero.
- FIRE: HS_WAIT goes to HS_PULSE when the count reaches the delay.
- CLIP: HS_PULSE goes to HS_HOLD when the count reaches the delay plus the width.
- DROP: any state goes to HS_IDLE when the sampled CRTC pulse is low.
- STAY: the state is kept otherwise.

Top module: `mon_sync_shaper`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high at a clock edge, the block clears `char_pos` to 0 and forces `mon_hs` and `mon_vs` to 0 and `csync_n` to 1, even in the middle of a pulse.
- R2: On an enabled cycle where `crtc_hs` is sampled 1 after being sampled 0 on the previous enabled cycle, `char_pos` becomes 0. On every other enabled cycle it rises by 1 and saturates at all ones (255 by default). Without `char_en` it holds its value.
- R3: `mon_hs` goes high on the enabled cycle where `char_pos` becomes H_DELAY (default 2), provided `crtc_hs` is still sampled high on that cycle.
- R4: When the CRTC pulse lasts H_DELAY+H_WIDTH characters or more (6 by default), `mon_hs` is high for exactly H_WIDTH characters (4), at counts 2 through 5. A CRTC pulse that starts at character 46 of a line and is 14 characters wide gives a monitor pulse on characters 48 through 51.
- R5: When the CRTC pulse is w characters wide, with H_DELAY < w < H_DELAY+H_WIDTH, `mon_hs` ends on the enabled cycle where `crtc_hs` is first sampled low. It is then high for w−H_DELAY characters.
- R6: A CRTC pulse of width H_DELAY or less produces no `mon_hs` pulse.
- R7: `mon_vs` takes the value of `crtc_vs` sampled on the enabled cycle where `mon_hs` rises. A `crtc_vs` change at any other time has no effect until the next monitor pulse begins.
- R8: `csync_n` is 0 when `mon_hs` and `mon_vs` differ and 1 when they are equal. It is an active-low sync whose horizontal pulses are inverted during vertical sync.
- R9: Changes on `crtc_hs` during cycles without `char_en` have no effect on `char_pos` or `mon_hs`.
- R10: With H_DELAY set to 1, the monitor pulse starts at count 1 and, for a wide CRTC pulse, ends after count 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| char_en | input | 1 | Character-clock enable, one cycle wide |
| crtc_hs | input | 1 | Horizontal sync from the timing generator, active high |
| crtc_vs | input | 1 | Vertical sync from the timing generator, active high |
| mon_hs | output | 1 | Reshaped horizontal sync, active high |
| mon_vs | output | 1 | Line-aligned vertical sync, active high |
| csync_n | output | 1 | Composite sync, active low |
| char_pos | output | CNT_W | Characters elapsed since the last CRTC horizontal sync rising edge |

## Verification
The bench drives CRTC pulses of widths 1 to 14, one at character 46 of a line, and checks every character of each line against a count-based expectation for both the default delay and a delay of 1.

Each corner case has a known failure mode:
- Off-by-one pulse start: a design that gets this wrong shifts the pulse by a character.
- Missing clip: the pulse follows a 14-wide CRTC pulse to its end.
- Narrow pulses: a design that mishandles them either keeps driving after the CRTC pulse falls or emits a sliver for a 2-wide input.
- Vertical sync changed before the monitor pulse starts: a design that copies it directly moves the transition off the line boundary.
- Short glitch on `crtc_hs` between enables: a design that samples without the enable restarts the count.
- Reset in mid-pulse: the outputs must still return to inactive.

// File: rtl/mss_pkg.sv
package mss_pkg;
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_WAIT  = 2'd1,
        HS_PULSE = 2'd2,
        HS_HOLD  = 2'd3
    } hs_state_t;
endpackage

// File: rtl/mss_hs_edge.sv
module mss_hs_edge (
    input  logic clk,
    input  logic rst,
    input  logic char_en,
    input  logic hs_in,
    output logic rise
);
    logic hs_prev;

    always_ff @(posedge clk) begin
        if (rst)
            hs_prev <= 1'b0;
        else if (char_en)
            hs_prev <= hs_in;
    end

    assign rise = char_en & hs_in & ~hs_prev;
endmodule

// File: rtl/mss_char_cnt.sv
module mss_char_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             char_en,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (char_en) begin
            if (clear)
                count <= '0;
            else if (count != CNT_MAX)
                count <= count + CNT_W'(1);
        end
    end

    // R2: one step per enabled character below saturation
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (char_en && !clear && count != CNT_MAX) |=> count == $past(count) + CNT_W'(1));

    // R9: no enable, no movement
    assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !char_en |=> $stable(count));
endmodule

// File: rtl/mss_hfsm.sv
module mss_hfsm
    import mss_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int H_DELAY = 2,
    parameter int H_WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             char_en,
    input  logic             hs_in,
    input  logic             rise,
    input  logic [CNT_W-1:0] count,
    output logic             pulse,
    output logic             line_start
);
    localparam logic [CNT_W:0] START_K = (CNT_W+1)'(H_DELAY);
    localparam logic [CNT_W:0] STOP_K  = (CNT_W+1)'(H_DELAY + H_WIDTH);

    hs_state_t      state, state_nxt;
    logic [CNT_W:0] k_next;

    assign k_next = rise ? '0 : ({1'b0, count} + (CNT_W+1)'(1));

    always_comb begin
        state_nxt = state;
        if (char_en) begin
            if (rise)
                state_nxt = (H_DELAY == 0) ? HS_PULSE : HS_WAIT;
            else if (!hs_in)
                state_nxt = HS_IDLE;
            else begin
                unique case (state)
                    HS_IDLE:  state_nxt = HS_IDLE;
                    HS_WAIT:  if (k_next == START_K) state_nxt = HS_PULSE;
                    HS_PULSE: if (k_next == STOP_K)  state_nxt = HS_HOLD;
                    HS_HOLD:  state_nxt = HS_HOLD;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= HS_IDLE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pulse <= 1'b0;
        else
            pulse <= (state_nxt == HS_PULSE);
    end

    assign line_start = char_en && (state_nxt == HS_PULSE) && (state != HS_PULSE);

    // R5: a low CRTC sample ends any monitor pulse
    assert_low_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (char_en && !hs_in) |=> !pulse);

    // R6: the pulse only ever comes out of the waiting state or a zero delay
    assert_no_early_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> ($past(state) == HS_WAIT || H_DELAY == 0));
endmodule

// File: rtl/mss_vs_align.sv
module mss_vs_align (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic vs_in,
    output logic vs_out
);
    always_ff @(posedge clk) begin
        if (rst)
            vs_out <= 1'b0;
        else if (take)
            vs_out <= vs_in;
    end
endmodule

// File: rtl/mon_sync_shaper.sv
module mon_sync_shaper #(
    parameter int CNT_W   = 8,
    parameter int H_DELAY = 2,
    parameter int H_WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             char_en,
    input  logic             crtc_hs,
    input  logic             crtc_vs,
    output logic             mon_hs,
    output logic             mon_vs,
    output logic             csync_n,
    output logic [CNT_W-1:0] char_pos
);
    localparam logic [CNT_W-1:0] POS_START = CNT_W'(H_DELAY);
    localparam logic [CNT_W-1:0] POS_STOP  = CNT_W'(H_DELAY + H_WIDTH);

    logic hs_rise;
    logic line_start;

    mss_hs_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .char_en (char_en),
        .hs_in   (crtc_hs),
        .rise    (hs_rise)
    );

    mss_char_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .char_en (char_en),
        .clear   (hs_rise),
        .count   (char_pos)
    );

    mss_hfsm #(.CNT_W(CNT_W), .H_DELAY(H_DELAY), .H_WIDTH(H_WIDTH)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .char_en    (char_en),
        .hs_in      (crtc_hs),
        .rise       (hs_rise),
        .count      (char_pos),
        .pulse      (mon_hs),
        .line_start (line_start)
    );

    mss_vs_align u_vs (
        .clk    (clk),
        .rst    (rst),
        .take   (line_start),
        .vs_in  (crtc_vs),
        .vs_out (mon_vs)
    );

    assign csync_n = ~(mon_hs ^ mon_vs);

    // R1: reset leaves every sync inactive
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!mon_hs && !mon_vs && char_pos == '0));

    // R3: the monitor pulse rises only at the delay count
    assert_start_pos_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mon_hs) |-> char_pos == POS_START);

    // R4: the monitor pulse lies inside the clip window
    assert_clip_window_R4: assert property (@(posedge clk) disable iff (rst)
        mon_hs |-> (char_pos >= POS_START && char_pos < POS_STOP));

    // R7: vertical sync moves only at a line boundary
    assert_vs_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(mon_vs) |-> $rose(mon_hs));
endmodule

// File: tb/sim_mon_sync_shaper.sv
module sim_mon_sync_shaper;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic char_en = 1'b0;
    logic crtc_hs = 1'b0;
    logic crtc_vs = 1'b0;
    logic hs0, vs0, cs0, hs1, vs1, cs1;
    logic [7:0] pos0, pos1;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic ev0 = 1'b0;
    logic ev1 = 1'b0;

    always #2.5 clk = ~clk;

    mon_sync_shaper u0 (
        .clk(clk), .rst(rst), .char_en(char_en), .crtc_hs(crtc_hs), .crtc_vs(crtc_vs),
        .mon_hs(hs0), .mon_vs(vs0), .csync_n(cs0), .char_pos(pos0)
    );

    mon_sync_shaper #(.H_DELAY(1)) u1 (
        .clk(clk), .rst(rst), .char_en(char_en), .crtc_hs(crtc_hs), .crtc_vs(crtc_vs),
        .mon_hs(hs1), .mon_vs(vs1), .csync_n(cs1), .char_pos(pos1)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic hs, input logic vs);
        @(negedge clk);
        crtc_hs = hs;
        crtc_vs = vs;
        char_en = 1'b1;
        @(negedge clk);
        char_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // one line: pre low characters, then a CRTC pulse of width w, checked for len characters
    task automatic run_line(input int pre, input int w, input int len, input logic vs,
                            input string req, output int first_hi, output int last_hi);
        first_hi = -1;
        last_hi  = -1;
        for (int i = 0; i < pre; i++) step(1'b0, vs);
        for (int j = 0; j < len; j++) begin
            bit e0, e1;
            step(j < w, vs);
            e0 = (j >= 2) && (j < 6) && (j < w);
            e1 = (j >= 1) && (j < 5) && (j < w);
            if (j == 2 && w > 2) ev0 = vs;
            if (j == 1 && w > 1) ev1 = vs;
            chk(req, "mon_hs", hs0, e0);
            chk("R2", "char_pos", pos0, j);
            chk("R7", "mon_vs", vs0, ev0);
            chk("R8", "csync_n", cs0, !(e0 ^ ev0));
            chk("R10", "mon_hs delay1", hs1, e1);
            chk("R7", "mon_vs delay1", vs1, ev1);
            if (hs0) begin
                if (first_hi < 0) first_hi = pre + j;
                last_hi = pre + j;
            end
        end
    endtask

    task automatic t_reset_state;
        chk("R1", "mon_hs", hs0, 0);
        chk("R1", "mon_vs", vs0, 0);
        chk("R1", "csync_n", cs0, 1);
        chk("R1", "char_pos", pos0, 0);
    endtask

    task automatic t_long_at_46;
        int f, l;
        run_line(46, 14, 16, 1'b0, "R4", f, l);
        chk("R4", "first char", f, 48);
        chk("R4", "last char", l, 51);
    endtask

    task automatic t_widths;
        int f, l;
        run_line(3, 6, 10, 1'b0, "R4", f, l);
        chk("R4", "width 6 length", l - f + 1, 4);
        run_line(3, 5, 8, 1'b0, "R5", f, l);
        chk("R5", "width 5 length", l - f + 1, 3);
        run_line(3, 4, 8, 1'b0, "R5", f, l);
        chk("R5", "width 4 length", l - f + 1, 2);
        run_line(3, 3, 8, 1'b0, "R3", f, l);
        chk("R3", "width 3 start", f, 3 + 2);
        run_line(3, 2, 8, 1'b0, "R6", f, l);
        chk("R6", "width 2 no pulse", f, -1);
        run_line(3, 1, 8, 1'b0, "R6", f, l);
        chk("R6", "width 1 no pulse", f, -1);
    endtask

    task automatic t_vsync;
        int f, l;
        // crtc_vs goes high during the low lead-in: mon_vs must wait for the pulse
        run_line(4, 14, 16, 1'b1, "R7", f, l);
        run_line(4, 14, 16, 1'b1, "R8", f, l);
        run_line(4, 14, 16, 1'b0, "R7", f, l);
        // narrow pulse gives no line start, so a vs change is not taken
        run_line(4, 1, 6, 1'b1, "R6", f, l);
    endtask

    task automatic t_glitch;
        int p;
        step(1'b0, 1'b0);
        p = pos0;
        @(negedge clk);
        crtc_hs = 1'b1;
        repeat (2) @(negedge clk);
        crtc_hs = 1'b0;
        @(negedge clk);
        chk("R9", "char_pos after glitch", pos0, p);
        chk("R9", "mon_hs after glitch", hs0, 0);
        step(1'b0, 1'b0);
        chk("R9", "no restart", pos0, (p == 255) ? 255 : p + 1);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 300; i++) step(1'b0, 1'b0);
        chk("R2", "saturated char_pos", pos0, 255);
    endtask

    task automatic t_mid_reset;
        step(1'b0, 1'b1);
        for (int j = 0; j < 4; j++) step(1'b1, 1'b1);
        chk("R3", "pulse active before reset", hs0, 1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ev0 = 1'b0;
        ev1 = 1'b0;
        t_reset_state();
        step(1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_long_at_46();
        t_widths();
        t_vsync();
        t_glitch();
        t_saturate();
        t_mid_reset();
        t_long_at_46();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule